// File: doc/BRIEF.md
# PATA PIO bus cycle generator

This block turns single host register accesses into timed parallel ATA programmed-I/O bus cycles for a CompactFlash card wired in True IDE mode. A host offers a request (address, write flag, 16-bit write word) with a valid/ready handshake. The block decodes the address into one of two chip-select windows, then runs one bus cycle on the device pins: chip selects, the 3-bit register address, the read or write strobe and the data bus. A read's result comes back on a separate one-cycle response strobe.

Bus timing comes from three programmable counts: setup, pulse and cycle length, all in clock periods. The block derives the real schedule from them. It adds one setup clock to damp ringing, keeps at least two clocks of recovery, and frames the chip select one clock inside the cycle at each end. The device's ready line can stretch the strobe. Host back-pressure follows directly from this: `req_ready` is low from the clock that accepts a request until the cycle's recovery is over. A request is taken only on a clock where both `req_valid` and `req_ready` are high. The response strobe carries no back-pressure; the host must take it when it appears.

Top module: `pata_pio_engine`

## Requirements
- R1: A request whose address bits [23:21] are 110 (task window) drives `ata_cs0_n` low during its chip-select frame and keeps `ata_cs1_n` high.
- R2: A request whose address bits [23:21] are 111 (control window) drives `ata_cs1_n` low during its chip-select frame and keeps `ata_cs0_n` high. The two chip selects are never low together.
- R3: `ata_da` carries host address bits [3:1] throughout the cycle. Address bit 0 has no effect.
- R4: A request outside both windows is accepted without `req_ready` dropping and makes no chip select or strobe. A read of this kind returns `rsp_rdata` = 0 with `rsp_valid` on the next clock.
- R5: Counting the first clock after acceptance as offset 0, the strobe asserts at offset S = programmed setup + 1.
- R6: With the device ready, the strobe stays low for P clocks. P is the programmed pulse, and a programmed pulse of 0 is treated as 1.
- R7: The cycle lasts L = max(programmed cycle, S + P + 2) clocks, and `req_ready` is low for exactly those L clocks (plus any stall). At least two clocks therefore separate the end of the strobe from the end of the cycle.
- R8: The active chip select is low from offset 1 to offset L-2 inclusive, which is L-2 clocks, and it covers the whole strobe.
- R9: A write uses the same S, P and L as a read. It strobes `ata_diow_n` and never `ata_dior_n`, and it drives `ata_dd_oe` high while the strobe is low. A read never raises `ata_dd_oe`.
- R10: A read samples `ata_dd_i` on the clock edge that ends the strobe's last clock.
- R11: Register index 0 in the task window moves all 16 bits. Every other register moves 8 bits on data bits [7:0]: writes drive bits [15:8] as zero, and reads return bits [15:8] as zero.
- R12: Each clock that `ata_iordy` is low while a strobe is active holds the strobe and lengthens both the strobe and the cycle by one clock.
- R13: After reset the counts are setup 4, pulse 15, cycle 30 (a 600 ns cycle at 50 MHz). A write of `cfg_wr` updates them, but a bus cycle already running keeps the counts it was accepted with.
- R14: A read that uses the bus raises `rsp_valid` for one clock, on the clock where `req_ready` returns high. A write gives no `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Load the three timing counts |
| cfg_setup | input | 8 | Setup count in clocks |
| cfg_pulse | input | 8 | Strobe pulse count in clocks |
| cfg_cycle | input | 8 | Cycle length count in clocks |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 24 | Host byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-clock read data strobe |
| rsp_rdata | output | 16 | Read data |
| ata_cs0_n | output | 1 | Task window chip select, active low |
| ata_cs1_n | output | 1 | Control window chip select, active low |
| ata_da | output | 3 | Device register address |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_dd_o | output | 16 | Data to device |
| ata_dd_oe | output | 1 | Data bus output enable |
| ata_dd_i | input | 16 | Data from device |
| ata_iordy | input | 1 | Device ready; low stretches the strobe |

## Verification
The assertions check several pin-level rules on every clock. The two chip selects are never active together, and the two strobes are never active together. A strobe only appears inside a chip-select frame. An idle block drives no chip select. A strobe is held while the device reports not ready, and every strobe is followed by chip select still held and a quiet clock of recovery. The bench's scenarios are needed for the rest, because these depend on programmed counts and data values: the exact strobe offset and width, the cycle length, the chip-select framing and the data lanes. The same goes for sampling at the strobe's last edge, timing changes applied only to the next cycle, and the response strobe.

// File: rtl/pata_pkg.sv
package pata_pkg;
  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_TASK = 2'd1,
    WIN_CTRL = 2'd2
  } win_e;

  localparam int DEV_DATA_W = 16;
  localparam int DEV_IDX_W  = 3;
endpackage

// File: rtl/pata_addr_decode.sv
module pata_addr_decode
  import pata_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0]    addr,
  output win_e                 win,
  output logic [DEV_IDX_W-1:0] idx,
  output logic                 wide
);
  localparam int SEL_LSB = ADDR_W - 3;
  localparam int IDX_LSB = 1;

  logic unused_addr_bits;
  assign unused_addr_bits = ^{addr[SEL_LSB-1:IDX_LSB+DEV_IDX_W], addr[0]};

  always_comb begin
    unique case (addr[SEL_LSB +: 3])
      3'b110:  win = WIN_TASK;
      3'b111:  win = WIN_CTRL;
      default: win = WIN_NONE;
    endcase
    idx  = addr[IDX_LSB +: DEV_IDX_W];
    // only the task-window data port is a 16-bit register
    wide = (win == WIN_TASK) && (idx == '0);
  end
endmodule

// File: rtl/pata_timing_calc.sv
module pata_timing_calc #(
  parameter int CNT_W = 8,
  localparam int LEN_W = CNT_W + 2
) (
  input  logic [CNT_W-1:0] setup_cnt,
  input  logic [CNT_W-1:0] pulse_cnt,
  input  logic [CNT_W-1:0] cycle_cnt,
  output logic [LEN_W-1:0] s_eff,
  output logic [LEN_W-1:0] p_eff,
  output logic [LEN_W-1:0] len_eff
);
  localparam logic [1:0] PAD = 2'b00;
  logic [LEN_W-1:0] min_len;
  logic [LEN_W-1:0] cyc_ext;

  always_comb begin
    s_eff   = {PAD, setup_cnt} + LEN_W'(1);      // ringing margin
    p_eff   = (pulse_cnt == '0) ? LEN_W'(1) : {PAD, pulse_cnt};
    min_len = s_eff + p_eff + LEN_W'(2);          // two recovery clocks
    cyc_ext = {PAD, cycle_cnt};
    len_eff = (cyc_ext < min_len) ? min_len : cyc_ext;
  end
endmodule

// File: rtl/pata_cycle_fsm.sv
module pata_cycle_fsm #(
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] s_in,
  input  logic [LEN_W-1:0] p_in,
  input  logic [LEN_W-1:0] len_in,
  input  logic             iordy,
  output logic             busy,
  output logic             cs_on,
  output logic             strb_on,
  output logic             capture,
  output logic             last
);
  logic [LEN_W-1:0] cnt_q, s_q, p_q, len_q;
  logic [LEN_W-1:0] strb_end;
  logic             hold;

  always_comb begin
    strb_end = s_q + p_q;
    strb_on  = busy && (cnt_q >= s_q) && (cnt_q < strb_end);
    cs_on    = busy && (cnt_q >= LEN_W'(1)) && (cnt_q <= len_q - LEN_W'(2));
    hold     = strb_on && !iordy;
    capture  = strb_on && !hold && (cnt_q == strb_end - LEN_W'(1));
    last     = busy && !hold && (cnt_q == len_q - LEN_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
      s_q   <= '0;
      p_q   <= '0;
      len_q <= '0;
    end else if (start && !busy) begin
      busy  <= 1'b1;
      cnt_q <= '0;
      s_q   <= s_in;
      p_q   <= p_in;
      len_q <= len_in;
    end else if (busy && !hold) begin
      if (last) begin
        busy  <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + LEN_W'(1);
      end
    end
  end

  // R7: the phase counter never runs past the latched cycle length
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q < len_q));
  // R12: a stalled strobe keeps its position
  a_r12_hold_count: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_on && !iordy) |=> (strb_on && $stable(cnt_q)));
endmodule

// File: rtl/pata_pio_engine.sv
module pata_pio_engine
  import pata_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int CNT_W     = 8,
  parameter int DEF_SETUP = 4,
  parameter int DEF_PULSE = 15,
  parameter int DEF_CYCLE = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CNT_W-1:0]  cfg_setup,
  input  logic [CNT_W-1:0]  cfg_pulse,
  input  logic [CNT_W-1:0]  cfg_cycle,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [15:0]       req_wdata,
  output logic              rsp_valid,
  output logic [15:0]       rsp_rdata,
  output logic              ata_cs0_n,
  output logic              ata_cs1_n,
  output logic [2:0]        ata_da,
  output logic              ata_dior_n,
  output logic              ata_diow_n,
  output logic [15:0]       ata_dd_o,
  output logic              ata_dd_oe,
  input  logic [15:0]       ata_dd_i,
  input  logic              ata_iordy
);
  localparam int LEN_W = CNT_W + 2;
  localparam int HALF  = DEV_DATA_W / 2;

  // timing configuration
  logic [CNT_W-1:0] setup_q, pulse_q, cycle_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup_q <= CNT_W'(DEF_SETUP);
      pulse_q <= CNT_W'(DEF_PULSE);
      cycle_q <= CNT_W'(DEF_CYCLE);
    end else if (cfg_wr) begin
      setup_q <= cfg_setup;
      pulse_q <= cfg_pulse;
      cycle_q <= cfg_cycle;
    end
  end

  logic [LEN_W-1:0] s_eff, p_eff, len_eff;
  pata_timing_calc #(.CNT_W(CNT_W)) u_calc (
    .setup_cnt(setup_q), .pulse_cnt(pulse_q), .cycle_cnt(cycle_q),
    .s_eff(s_eff), .p_eff(p_eff), .len_eff(len_eff)
  );

  // request decode
  win_e                 dec_win;
  logic [DEV_IDX_W-1:0] dec_idx;
  logic                 dec_wide;
  pata_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(req_addr), .win(dec_win), .idx(dec_idx), .wide(dec_wide)
  );

  logic busy, cs_on, strb_on, capture, last;
  logic accept, hit;
  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign hit       = (dec_win != WIN_NONE);

  pata_cycle_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(accept && hit),
    .s_in(s_eff), .p_in(p_eff), .len_in(len_eff), .iordy(ata_iordy),
    .busy(busy), .cs_on(cs_on), .strb_on(strb_on),
    .capture(capture), .last(last)
  );

  // per-access context
  win_e                  win_q;
  logic [DEV_IDX_W-1:0]  idx_q;
  logic                  wide_q, write_q;
  logic [DEV_DATA_W-1:0] wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q   <= WIN_NONE;
      idx_q   <= '0;
      wide_q  <= 1'b0;
      write_q <= 1'b0;
      wdata_q <= '0;
    end else if (accept && hit) begin
      win_q   <= dec_win;
      idx_q   <= dec_idx;
      wide_q  <= dec_wide;
      write_q <= req_write;
      wdata_q <= req_wdata;
    end
  end

  // response path
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= (accept && !hit && !req_write) || (last && !write_q);
      if (accept && !hit && !req_write)
        rsp_rdata <= '0;
      else if (capture && !write_q)
        rsp_rdata <= wide_q ? ata_dd_i : {{HALF{1'b0}}, ata_dd_i[HALF-1:0]};
    end
  end

  // device pins
  assign ata_cs0_n  = !(cs_on && (win_q == WIN_TASK));
  assign ata_cs1_n  = !(cs_on && (win_q == WIN_CTRL));
  assign ata_da     = busy ? idx_q : '0;
  assign ata_dior_n = !(strb_on && !write_q);
  assign ata_diow_n = !(strb_on && write_q);
  assign ata_dd_oe  = cs_on && write_q;
  assign ata_dd_o   = wide_q ? wdata_q : {{HALF{1'b0}}, wdata_q[HALF-1:0]};

  logic any_strb, any_cs;
  assign any_strb = !ata_dior_n || !ata_diow_n;
  assign any_cs   = !ata_cs0_n || !ata_cs1_n;

  a_r2_cs_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ata_cs0_n && !ata_cs1_n));
  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ata_dior_n && !ata_diow_n));
  a_r8_strobe_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
    any_strb |-> any_cs);
  a_r7_idle_no_cs: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ata_cs0_n && ata_cs1_n && !any_strb));
  a_r12_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (any_strb && !ata_iordy) |=> any_strb);
  a_r7_recovery_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(any_strb) |=> !any_strb);
  a_r8_cs_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(any_strb) |-> any_cs);
endmodule

// File: tb/tb_pata_pio_engine.sv
module tb_pata_pio_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_setup = '0, cfg_pulse = '0, cfg_cycle = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        ata_cs0_n, ata_cs1_n, ata_dior_n, ata_diow_n, ata_dd_oe;
  logic [2:0]  ata_da;
  logic [15:0] ata_dd_o;
  logic [15:0] ata_dd_i = 16'hDEAD;
  logic        ata_iordy = 1'b1;

  always #10 clk = ~clk;

  pata_pio_engine dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_setup(cfg_setup),
    .cfg_pulse(cfg_pulse), .cfg_cycle(cfg_cycle), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ata_cs0_n(ata_cs0_n), .ata_cs1_n(ata_cs1_n), .ata_da(ata_da),
    .ata_dior_n(ata_dior_n), .ata_diow_n(ata_diow_n), .ata_dd_o(ata_dd_o),
    .ata_dd_oe(ata_dd_oe), .ata_dd_i(ata_dd_i), .ata_iordy(ata_iordy)
  );

  int nchk = 0, nerr = 0;

  task automatic check(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [7:0]  su, pu, cy;
    logic        wr;
    logic [23:0] addr;
    logic [15:0] wd;
    logic [7:0]  stall;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{8'd4, 8'd15, 8'd30, 1'b0, 24'hC00000, 16'h0000, 8'd0},
    '{8'd0, 8'd1,  8'd0,  1'b1, 24'hC0000E, 16'hA5EC, 8'd0},
    '{8'd2, 8'd3,  8'd20, 1'b0, 24'hE0000C, 16'h0000, 8'd0},
    '{8'd1, 8'd0,  8'd3,  1'b1, 24'hC00000, 16'h1234, 8'd0},
    '{8'd3, 8'd4,  8'd6,  1'b0, 24'hC00004, 16'h0000, 8'd3},
    '{8'd0, 8'd2,  8'd9,  1'b1, 24'hE0000D, 16'hBEEF, 8'd2}
  };

  // measurements of the last access
  int m_busy, m_csf, m_csn, m_sf, m_sn, m_other, m_cs0, m_cs1, m_da, m_dd, m_oe, m_oe_rd;
  int m_rv, m_rd, m_rv2;

  task automatic set_cfg(logic [7:0] su, logic [7:0] pu, logic [7:0] cy);
    @(negedge clk);
    cfg_setup = su; cfg_pulse = pu; cfg_cycle = cy; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic access(logic wr, logic [23:0] addr, logic [15:0] wd, int stall,
                        logic [15:0] dev, bit chg, logic [7:0] nsu,
                        logic [7:0] npu, logic [7:0] ncy);
    int t, left;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
    ata_dd_i = 16'hDEAD;
    @(negedge clk);
    req_valid = 1'b0;
    m_csf = -1; m_csn = 0; m_sf = -1; m_sn = 0; m_other = 0; m_cs0 = 0;
    m_cs1 = 0; m_da = -1; m_dd = -1; m_oe = 0; m_oe_rd = 0; left = 0; t = 0;
    while (!req_ready && t < 1000) begin
      if (chg && t == 2) begin
        cfg_setup = nsu; cfg_pulse = npu; cfg_cycle = ncy; cfg_wr = 1'b1;
      end
      if (chg && t == 3) cfg_wr = 1'b0;
      if (!ata_cs0_n || !ata_cs1_n) begin
        if (m_csf < 0) m_csf = t;
        m_csn++;
        if (!ata_cs0_n) m_cs0 = 1;
        if (!ata_cs1_n) m_cs1 = 1;
      end
      if (!wr && ata_dd_oe) m_oe_rd = 1;
      if (wr ? !ata_dior_n : !ata_diow_n) m_other = 1;
      if (left > 0) begin
        left--;
        if (left == 0) ata_iordy = 1'b1;
      end
      if (wr ? !ata_diow_n : !ata_dior_n) begin
        if (m_sf < 0) begin
          m_sf = t;
          ata_dd_i = dev;
          if (stall > 0) begin ata_iordy = 1'b0; left = stall; end
        end
        m_sn++;
        m_da = int'(ata_da);
        m_dd = int'(ata_dd_o);
        m_oe = int'(ata_dd_oe);
      end else if (m_sf >= 0) begin
        ata_dd_i = 16'hDEAD;
      end
      @(negedge clk);
      t++;
    end
    cfg_wr = 1'b0;
    m_busy = t;
    m_rv = int'(rsp_valid);
    m_rd = int'(rsp_rdata);
    @(negedge clk);
    m_rv2 = int'(rsp_valid);
  endtask

  task automatic expect_access(string tag, int su, int pu, int cy, logic wr,
                               logic [23:0] addr, logic [15:0] wd, int stall,
                               logic [15:0] dev);
    int s, p, l;
    bit wide;
    s = su + 1;
    p = (pu == 0) ? 1 : pu;
    l = (cy < s + p + 2) ? s + p + 2 : cy;
    wide = (addr[23:21] == 3'b110) && (addr[3:1] == 3'd0);
    check({tag, " R7 busy clocks"}, m_busy, l + stall);
    check({tag, " R8 cs first offset"}, m_csf, 1);
    check({tag, " R8 cs clocks"}, m_csn, l - 2 + stall);
    check({tag, " R1 cs0 use"}, m_cs0, int'(addr[23:21] == 3'b110));
    check({tag, " R2 cs1 use"}, m_cs1, int'(addr[23:21] == 3'b111));
    check({tag, " R3 device address"}, m_da, int'(addr[3:1]));
    check({tag, " R5 strobe offset"}, m_sf, s);
    check({tag, " R6 R12 strobe clocks"}, m_sn, p + stall);
    check({tag, " R9 other strobe idle"}, m_other, 0);
    if (wr) begin
      check({tag, " R9 dd_oe in strobe"}, m_oe, 1);
      check({tag, " R11 write lanes"}, m_dd, wide ? int'(wd) : int'(wd[7:0]));
      check({tag, " R14 no write response"}, m_rv, 0);
    end else begin
      check({tag, " R9 no dd_oe on read"}, m_oe_rd, 0);
      check({tag, " R14 read response"}, m_rv, 1);
      check({tag, " R10 R11 read data"}, m_rd, wide ? int'(dev) : int'(dev[7:0]));
    end
    check({tag, " R14 response one clock"}, m_rv2, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 reset ready", int'(req_ready), 1);
    check("R1 reset cs0", int'(ata_cs0_n), 1);
    check("R2 reset cs1", int'(ata_cs1_n), 1);
    check("R9 reset strobes", int'({ata_dior_n, ata_diow_n}), 3);
    check("R14 reset rsp", int'(rsp_valid), 0);
    check("R9 reset dd_oe", int'(ata_dd_oe), 0);

    // R13 reset defaults: setup 4, pulse 15, cycle 30
    access(1'b0, 24'hC00002, 16'h0, 0, 16'h77B1, 1'b0, 8'd0, 8'd0, 8'd0);
    expect_access("default", 4, 15, 30, 1'b0, 24'hC00002, 16'h0, 0, 16'h77B1);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [15:0] dev;
      string tag;
      v = VECS[i];
      dev = {8'(8'h90 + i), 8'(8'h3C + i)};
      tag = $sformatf("vec%0d", i);
      set_cfg(v.su, v.pu, v.cy);
      access(v.wr, v.addr, v.wd, int'(v.stall), dev, 1'b0, 8'd0, 8'd0, 8'd0);
      expect_access(tag, int'(v.su), int'(v.pu), int'(v.cy), v.wr, v.addr,
                    v.wd, int'(v.stall), dev);
    end

    // R13 a change during a cycle applies to the next one only
    set_cfg(8'd2, 8'd2, 8'd12);
    access(1'b1, 24'hC00006, 16'h4455, 0, 16'h0, 1'b1, 8'd0, 8'd1, 8'd0);
    expect_access("R13 old", 2, 2, 12, 1'b1, 24'hC00006, 16'h4455, 0, 16'h0);
    access(1'b0, 24'hE0000C, 16'h0, 0, 16'h6622, 1'b0, 8'd0, 8'd0, 8'd0);
    expect_access("R13 new", 0, 1, 0, 1'b0, 24'hE0000C, 16'h0, 0, 16'h6622);

    // R4 request outside both windows
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 24'h400006;
    @(negedge clk);
    req_valid = 1'b0;
    check("R4 ready stays high", int'(req_ready), 1);
    check("R4 no chip select", int'({ata_cs0_n, ata_cs1_n}), 3);
    check("R4 read response", int'(rsp_valid), 1);
    check("R4 read data zero", int'(rsp_rdata), 0);
    @(negedge clk);
    check("R4 response one clock", int'(rsp_valid), 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule